// File: doc/BRIEF.md
# Flash block-lock command decoder

This block is the device-side command interpreter of a partitioned flash model. Each bus write cycle carries a command code in its low data byte. The block turns these codes into read-mode changes, two-cycle lock operations and status updates. It keeps a lock bit and a lock-down bit for every block, a small status register and a busy timer. A combinational read path chooses what a bus read returns: array data, the status register, or identifier and lock information.

The array is an erased register model, so an array read always returns all ones. A lock operation needs two writes. The first write arms the operation, and its address selects the block. The second write is the confirm code, and it chooses between a plain lock and a lock-down. A wrong confirm code sets two sticky error bits in the status register. After a valid confirm, the engine reports busy for a fixed number of cycles.

The block number is the upper `ADDR_W-BLK_SHIFT` bits of the address. The offset within a block is the low `BLK_SHIFT` bits.

Top module: `blk_lock_cui`

## Requirements
- R1: After reset, reads are in array mode, no block has its lock or lock-down bit set, and the status register reads 0x0080.
- R2: A write of 0x60 followed by a write of 0x01 sets the lock bit of the block addressed by the first (arming) write, and of no other block.
- R3: A write of 0x60 followed by a write of 0x2F sets both the lock-down bit and the lock bit of the armed block. A lock-down bit, once set, stays set until reset; a later lock command on the same block leaves it set.
- R4: If the write after 0x60 is any code other than 0x01 or 0x2F, status bits 5 and 4 are both set (status reads 0x00B0 when ready), no lock bit changes, and no busy period starts.
- R5: Status bits 5 and 4 stay set across later commands and lock operations until a write of 0x50. That write clears them, leaves bit 7 alone, and does not change the read mode.
- R6: After a write of 0x70, a read at any address returns the status register in the low byte, with zeros above. Bit 7 is ready, bits 5 and 4 are the error flags, and all other bits are 0.
- R7: After a write of 0x90, a read at offset 2 of a block returns the lock bit on bit 0 and the lock-down bit on bit 1. Offset 0 returns MFR_ID, offset 1 returns DEV_ID, and any other offset returns 0.
- R8: After a write of 0xFF, reads return all ones (array mode).
- R9: After a valid confirm write, status bit 7 reads 0 for exactly BUSY_CYC cycles, starting in the cycle that follows the confirm edge, and then reads 1. Any completed two-cycle sequence, valid or not, leaves the block in status mode.
- R10: While busy, every read returns the status register, and every write is ignored, including the mode and arming commands.
- R11: Commands are decoded from bits 7:0 of the write data only, and the upper bits are ignored. A code that is not a command leaves the mode and all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write cycle strobe, sampled on the rising edge |
| addr | input | ADDR_W | Word address for writes and reads |
| wdata | input | DATA_W | Write data; the command code is in bits 7:0 |
| rdata | output | DATA_W | Read data for the current address and mode |

## Verification
A wrong mode register shows up at once on `rdata`: the very next read returns array ones, status or identifier data, and the check catches the mismatch. A corrupted lock or lock-down bit stays hidden until the block's offset 2 is read in identifier mode, so the tests read back every block they touch and also a neighbouring block. A busy counter that is off by one is visible only at the exact cycle where ready returns, so bit 7 is sampled both just before and exactly at that boundary. An error flag that is lost or cleared too early appears only after later operations, so the tests issue valid lock sequences between the fault and the clear command.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_STATUS = 2'd1,
        MD_IDENT  = 2'd2
    } rd_mode_e;

    localparam logic [7:0] OP_ARM    = 8'h60;
    localparam logic [7:0] OP_LOCK   = 8'h01;
    localparam logic [7:0] OP_DOWN   = 8'h2F;
    localparam logic [7:0] OP_STATUS = 8'h70;
    localparam logic [7:0] OP_IDENT  = 8'h90;
    localparam logic [7:0] OP_CLEAR  = 8'h50;
    localparam logic [7:0] OP_ARRAY  = 8'hFF;

    localparam int unsigned SR_READY_BIT = 7;
    localparam int unsigned SR_ERR_HI    = 5;
    localparam int unsigned SR_ERR_LO    = 4;

endpackage

// File: rtl/blk_lock_timer.sv
module blk_lock_timer #(
    parameter int unsigned BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(BUSY_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/blk_lock_bits.sv
module blk_lock_bits #(
    parameter int unsigned NUM_BLK = 16,
    parameter int unsigned BLK_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_lock,
    input  logic               set_down,
    input  logic [BLK_W-1:0]   tgt_blk,
    output logic [NUM_BLK-1:0] lock_vec,
    output logic [NUM_BLK-1:0] down_vec
);
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        logic lk_d, lk_q, dn_d, dn_q;
        logic hit;

        assign hit = (tgt_blk == BLK_W'(b));

        always_comb begin
            lk_d = lk_q;
            dn_d = dn_q;
            if (hit && (set_lock || set_down)) lk_d = 1'b1;
            if (hit && set_down)               dn_d = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lk_q <= 1'b0;
                dn_q <= 1'b0;
            end else begin
                lk_q <= lk_d;
                dn_q <= dn_d;
            end
        end

        assign lock_vec[b] = lk_q;
        assign down_vec[b] = dn_q;
    end

endmodule

// File: rtl/blk_lock_rdmux.sv
module blk_lock_rdmux
    import blk_lock_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned BLK_SHIFT = 8,
    parameter int unsigned NUM_BLK   = 16,
    parameter logic [15:0] MFR_ID    = 16'h00B0,
    parameter logic [15:0] DEV_ID    = 16'h00E2
) (
    input  rd_mode_e           mode,
    input  logic               busy,
    input  logic [7:0]         status,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_BLK-1:0] lock_vec,
    input  logic [NUM_BLK-1:0] down_vec,
    output logic [DATA_W-1:0]  rdata
);
    localparam int unsigned BLK_W = ADDR_W - BLK_SHIFT;

    logic [BLK_SHIFT-1:0] offs;
    logic [BLK_W-1:0]     blk;

    assign offs = addr[BLK_SHIFT-1:0];
    assign blk  = addr[ADDR_W-1:BLK_SHIFT];

    always_comb begin
        rdata = '0;
        if (busy || mode == MD_STATUS) begin
            rdata[7:0] = status;
        end else if (mode == MD_ARRAY) begin
            rdata = '1;
        end else begin
            if (offs == BLK_SHIFT'(0)) begin
                rdata = DATA_W'(MFR_ID);
            end else if (offs == BLK_SHIFT'(1)) begin
                rdata = DATA_W'(DEV_ID);
            end else if (offs == BLK_SHIFT'(2)) begin
                rdata[0] = lock_vec[blk];
                rdata[1] = down_vec[blk];
            end
        end
    end

endmodule

// File: rtl/blk_lock_cui.sv
module blk_lock_cui
    import blk_lock_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned BLK_SHIFT = 8,
    parameter int unsigned BUSY_CYC  = 4,
    parameter logic [15:0] MFR_ID    = 16'h00B0,
    parameter logic [15:0] DEV_ID    = 16'h00E2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned BLK_W   = ADDR_W - BLK_SHIFT;
    localparam int unsigned NUM_BLK = 1 << BLK_W;

    typedef struct packed {
        rd_mode_e         mode;
        logic             armed;
        logic [BLK_W-1:0] arm_blk;
        logic             sr_err;
    } cui_state_t;

    cui_state_t st_d, st_q;

    logic               busy;
    logic               set_lock, set_down, start;
    logic [7:0]         opc;
    logic [7:0]         status;
    logic [NUM_BLK-1:0] lock_vec, down_vec;
    logic               armed_w, sr_err_w;

    assign opc = wdata[7:0];

    always_comb begin
        st_d     = st_q;
        set_lock = 1'b0;
        set_down = 1'b0;
        start    = 1'b0;
        if (wr_en && !busy) begin
            if (st_q.armed) begin
                st_d.armed = 1'b0;
                st_d.mode  = MD_STATUS;
                if (opc == OP_LOCK) begin
                    set_lock = 1'b1;
                    start    = 1'b1;
                end else if (opc == OP_DOWN) begin
                    set_down = 1'b1;
                    start    = 1'b1;
                end else begin
                    st_d.sr_err = 1'b1;
                end
            end else begin
                case (opc)
                    OP_ARM: begin
                        st_d.armed   = 1'b1;
                        st_d.arm_blk = addr[ADDR_W-1:BLK_SHIFT];
                    end
                    OP_STATUS: st_d.mode   = MD_STATUS;
                    OP_IDENT:  st_d.mode   = MD_IDENT;
                    OP_ARRAY:  st_d.mode   = MD_ARRAY;
                    OP_CLEAR:  st_d.sr_err = 1'b0;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_ARRAY, armed: 1'b0, arm_blk: '0, sr_err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status = '0;
        status[SR_READY_BIT] = ~busy;
        status[SR_ERR_HI]    = st_q.sr_err;
        status[SR_ERR_LO]    = st_q.sr_err;
    end

    assign armed_w  = st_q.armed;
    assign sr_err_w = st_q.sr_err;

    blk_lock_timer #(
        .BUSY_CYC (BUSY_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy)
    );

    blk_lock_bits #(
        .NUM_BLK (NUM_BLK),
        .BLK_W   (BLK_W)
    ) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_lock (set_lock),
        .set_down (set_down),
        .tgt_blk  (st_q.arm_blk),
        .lock_vec (lock_vec),
        .down_vec (down_vec)
    );

    blk_lock_rdmux #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BLK_SHIFT (BLK_SHIFT),
        .NUM_BLK   (NUM_BLK),
        .MFR_ID    (MFR_ID),
        .DEV_ID    (DEV_ID)
    ) u_rdmux (
        .mode     (st_q.mode),
        .busy     (busy),
        .status   (status),
        .addr     (addr),
        .lock_vec (lock_vec),
        .down_vec (down_vec),
        .rdata    (rdata)
    );

endmodule

// File: rtl/blk_lock_chk.sv
module blk_lock_chk #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned NUM_BLK = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  rdata,
    input logic               busy,
    input logic               armed,
    input logic               sr_err,
    input logic [NUM_BLK-1:0] lock_vec,
    input logic [NUM_BLK-1:0] down_vec
);
    logic       take;
    logic [7:0] op;

    assign take = wr_en && !busy;
    assign op   = wdata[7:0];

    // R3
    lockdown_has_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (down_vec & ~lock_vec) == '0);

    // R3
    lockdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((down_vec & $past(down_vec)) == $past(down_vec)));

    // R4
    bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && armed && op != 8'h01 && op != 8'h2F) |=> (sr_err && !busy));

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_err && !(take && op == 8'h50)) |=> sr_err);

    // R9
    confirm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && armed && (op == 8'h01 || op == 8'h2F)) |=> busy);

    // R10
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ($stable(lock_vec) && $stable(sr_err) && $stable(armed)));

    // R10
    busy_reads_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rdata[7] == 1'b0 && rdata[DATA_W-1:8] == '0));

endmodule

bind blk_lock_cui blk_lock_chk #(
    .DATA_W  (DATA_W),
    .NUM_BLK (NUM_BLK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .busy     (busy),
    .armed    (armed_w),
    .sr_err   (sr_err_w),
    .lock_vec (lock_vec),
    .down_vec (down_vec)
);

// File: tb/sim_blk_lock_cui.sv
module sim_blk_lock_cui;
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned DATA_W   = 16;
    localparam int unsigned BUSY_CYC = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    blk_lock_cui #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BUSY_CYC (BUSY_CYC)
    ) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 array after reset", 12'h000, 16'hFFFF);
        rd_chk("R8 array ones", 12'h7A5, 16'hFFFF);
        wr(12'h000, 16'h0090);
        rd_chk("R1 no lock at reset blk0", 12'h002, 16'h0000);
        rd_chk("R1 no lock at reset blk5", 12'h502, 16'h0000);
        wr(12'h000, 16'h0070);
        rd_chk("R1 status after reset", 12'h000, 16'h0080);
        wr(12'h000, 16'h00FF);
    endtask

    task automatic t_lock;
        wr(12'h300, 16'h0060);
        wr(12'h7F0, 16'h0001);
        rd_chk("R9 busy right after confirm", 12'h000, 16'h0000);
        tick(BUSY_CYC - 1);
        rd_chk("R9 busy on last busy cycle", 12'h000, 16'h0000);
        tick(1);
        rd_chk("R9 ready after busy time", 12'h000, 16'h0080);
        wr(12'h000, 16'h0090);
        rd_chk("R2 armed block locked", 12'h302, 16'h0001);
        rd_chk("R2 confirm-address block untouched", 12'h702, 16'h0000);
        rd_chk("R2 neighbour block untouched", 12'h402, 16'h0000);
        rd_chk("R7 manufacturer id", 12'h300, 16'h00B0);
        rd_chk("R7 device id", 12'h301, 16'h00E2);
        rd_chk("R7 other offset", 12'h305, 16'h0000);
        wr(12'h000, 16'h00FF);
    endtask

    task automatic t_lockdown;
        wr(12'h500, 16'h0060);
        wr(12'h500, 16'h002F);
        tick(BUSY_CYC);
        wr(12'h000, 16'h0090);
        rd_chk("R3 lock-down sets both bits", 12'h502, 16'h0003);
        wr(12'h500, 16'h0060);
        wr(12'h500, 16'h0001);
        tick(BUSY_CYC);
        wr(12'h000, 16'h0090);
        rd_chk("R3 lock-down survives later lock", 12'h502, 16'h0003);
        wr(12'h000, 16'h00FF);
    endtask

    task automatic t_seq_err;
        wr(12'h900, 16'h0060);
        wr(12'h900, 16'h0055);
        rd_chk("R4 bad confirm sets error, no busy", 12'h000, 16'h00B0);
        wr(12'h000, 16'h0090);
        rd_chk("R4 no lock after bad confirm", 12'h902, 16'h0000);
        wr(12'hA00, 16'h0060);
        wr(12'hA00, 16'h0001);
        tick(BUSY_CYC);
        rd_chk("R5 error sticky over lock op", 12'h000, 16'h00B0);
        wr(12'h000, 16'h0050);
        rd_chk("R5 clear keeps status mode and ready", 12'h000, 16'h0080);
        wr(12'h000, 16'h00FF);
        wr(12'h000, 16'h0050);
        rd_chk("R5 clear in array mode keeps array", 12'h000, 16'hFFFF);
    endtask

    task automatic t_busy;
        wr(12'hB00, 16'h0060);
        wr(12'hB00, 16'h0001);
        wr(12'h000, 16'h00FF);
        wr(12'hC00, 16'h0060);
        addr = 12'h000;
        rd_chk("R10 read during busy returns status", 12'h123, 16'h0000);
        tick(BUSY_CYC);
        rd_chk("R10 read-array write ignored while busy", 12'h000, 16'h0080);
        wr(12'hC00, 16'h0001);
        wr(12'h000, 16'h0090);
        rd_chk("R10 arm write ignored while busy", 12'hC02, 16'h0000);
        wr(12'h000, 16'h00FF);
    endtask

    task automatic t_decode;
        wr(12'h000, 16'h0033);
        rd_chk("R11 unknown code ignored", 12'h010, 16'hFFFF);
        wr(12'h000, 16'hAB70);
        rd_chk("R11 upper byte ignored", 12'h000, 16'h0080);
        rd_chk("R6 status at any address", 12'hFFF, 16'h0080);
        wr(12'h000, 16'h12FF);
        rd_chk("R8 read array restored", 12'h456, 16'hFFFF);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_lock();
        t_lockdown();
        t_seq_err();
        t_busy();
        t_decode();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule